// File: doc/BRIEF.md
# Oversampled Manchester Byte Receiver

This block turns a Manchester-coded serial line back into 8-bit bytes. A sample clock runs at sixteen times the bit rate. Every bit cell carries a transition at its centre, and the direction of that transition gives the data bit. The receiver passes the line through a two-flop synchroniser and then watches for edges. It takes the first edge it sees as a cell centre. After that it accepts the next edge only once a blanking interval has passed. This blanking discards the transitions that sit on cell boundaries between equal bits.

Each accepted centre edge restarts the receiver's cell timer, so the bit timing is re-aligned on every bit. Small rate differences and cell-length jitter are therefore tolerated. Decoded bits enter a shift register with the most significant bit first. When the eighth bit arrives, the completed byte is presented and a one-cycle strobe is raised. If no centre edge arrives within one and a half cell times, the receiver drops lock, discards the partial byte and raises an error flag. The error flag stays set until a later byte completes.

The block assumes that before the first bit, the line rests at the level of that bit's first half-cell. Under this assumption the first edge the receiver sees is a centre edge.

Top module: `manch_byte_rx`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the receiver clears `byte_out` to 0x00, `byte_valid` to 0, `err` to 0, the bit count and the lock state. Reset is synchronous and active low.
- R2: A centre-cell transition decodes as follows: high-to-low gives 1 and low-to-high gives 0. Each bit spans 16 sample clocks, split into two halves of 8. For example, byte 0xB9 travels as the half-cell levels 1001101010010110.
- R3: Bits are assembled most significant first. After the eighth accepted centre edge, `byte_out` shows the assembled byte and `byte_valid` is high for exactly one clock.
- R4: `byte_out` changes only together with a `byte_valid` pulse. It keeps its value through idle time and through an error.
- R5: The line passes through two synchroniser flops. `byte_valid` goes high on the third rising clock edge after the line's final centre transition is first sampled.
- R6: Once an edge has been accepted, any line edge fewer than 12 sample clocks after it is ignored. This covers cell-boundary transitions and short glitches.
- R7: Every accepted edge restarts the cell timer. Cells of 14 to 18 sample clocks, with half-cells of 7 to 9, still decode correctly.
- R8: If 24 sample clocks pass after an accepted edge with no further accepted edge, `err` is set, the bit count returns to zero and lock is dropped. The next byte is then assembled from its first bit.
- R9: `err` clears when a byte completes, and it stays low while centre edges keep arriving on time.
- R10: The line level present when reset is released does not count as an edge. While lock is not held, the first edge is accepted as a centre edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 16x the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Asynchronous Manchester serial line |
| byte_out | output | 8 | Last completed byte |
| byte_valid | output | 1 | One-cycle strobe when a byte completes |
| err | output | 1 | Set on loss of centre edges, cleared by the next completed byte |

## Verification
The bench targets the following corner cases and the fault each one exposes:

- **Cell-boundary edges between repeated bits.** A receiver with no blanking would decode these as extra bits and shift the byte out of place.
- **A glitch pair just after a centre edge.** This would insert spurious bits into the byte.
- **Cells of varying length.** This exposes a receiver that free-runs on a fixed 16-count instead of re-aligning on each edge: its decision point drifts onto the wrong edges.
- **A byte cut off after four bits, then a full byte.** A receiver that keeps the stale bit count would complete a mixed byte after only four new bits. One that never flags the gap would leave `err` low.
- **Strobe latency.** Checking the exact strobe cycle catches a synchroniser with the wrong number of stages.

// File: rtl/mdec_pkg.sv
// Package: shared defaults and the edge event type for the Manchester byte receiver.
// Assumes: one bit cell spans CELL_CYC sample clocks; derived windows scale from it.
package mdec_pkg;
    localparam int DEF_CELL_CYC = 16;
    localparam int DEF_DATA_W   = 8;

    // Edge event from the line synchroniser: an edge was seen, and its direction.
    typedef struct packed {
        logic seen;
        logic fall;
    } line_edge_t;
endpackage

// File: rtl/mdec_line_sync.sv
// Module: mdec_line_sync
// Purpose: brings the asynchronous serial line into the clock domain through
//          SYNC_STAGES flops and reports each level change as an edge event.
// Assumes: edges are reported only after the pipeline has filled since reset,
//          so the level held at reset release is never seen as a transition.
module mdec_line_sync
    import mdec_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_in,
    output line_edge_t edge_o
);
    localparam int FILL_MAX = SYNC_STAGES + 1;
    localparam int FILL_W   = $clog2(FILL_MAX + 1);

    logic [SYNC_STAGES-1:0] stage_q;
    logic                   prev_q;
    logic [FILL_W-1:0]      fill_q;
    logic                   primed;

    // Synchroniser chain: stage 0 samples the raw line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[SYNC_STAGES-2:0], line_in};
        end
    end

    // History flop holding the previous synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= stage_q[SYNC_STAGES-1];
        end
    end

    // Fill counter: marks when both compared levels come from real samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (fill_q != FILL_W'(FILL_MAX)) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    assign primed = (fill_q == FILL_W'(FILL_MAX));

    // Edge report: a change between the newest synchronised level and history.
    always_comb begin
        edge_o.seen = primed && (stage_q[SYNC_STAGES-1] != prev_q);
        edge_o.fall = !stage_q[SYNC_STAGES-1];
    end
endmodule

// File: rtl/mdec_cell_timer.sv
// Module: mdec_cell_timer
// Purpose: decides which line edges are cell centres. It blanks edges that
//          come too soon after the last accepted one, restarts its timer on
//          every accepted edge, and flags a timeout when centres stop.
// Assumes: BLANK_CYC < TMO_CYC; while unlocked, the first edge is a centre.
module mdec_cell_timer
    import mdec_pkg::*;
#(
    parameter int BLANK_CYC = 12,
    parameter int TMO_CYC   = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  line_edge_t edge_i,
    output logic       take_o,
    output logic       bit_o,
    output logic       tmo_o
);
    localparam int CNT_W = $clog2(TMO_CYC + 1);
    localparam logic [CNT_W-1:0] BLANK_C = CNT_W'(BLANK_CYC);
    localparam logic [CNT_W-1:0] TMO_C   = CNT_W'(TMO_CYC);
    localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(TMO_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             locked_q;

    // Acceptance: any edge while unlocked, otherwise only outside the blank window.
    assign take_o = edge_i.seen && (!locked_q || (cnt_q >= BLANK_C));
    // High-to-low centre transition carries a one.
    assign bit_o  = edge_i.fall;
    // Timeout: locked, no accepted edge, and the window is used up.
    assign tmo_o  = locked_q && !take_o && (cnt_q == LAST_C);

    // Cell timer: restarts on each accepted edge, saturates at the timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (take_o) begin
            cnt_q <= '0;
        end else if (cnt_q != TMO_C) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Lock state: gained on an accepted edge, lost on timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
        end else if (take_o) begin
            locked_q <= 1'b1;
        end else if (tmo_o) begin
            locked_q <= 1'b0;
        end
    end

    // An accepted edge restarts timing and holds lock.
    assert_realign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> (cnt_q == '0) && locked_q);

    // A timeout always drops lock.
    assert_drop_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_o |=> !locked_q);
endmodule

// File: rtl/mdec_byte_shift.sv
// Module: mdec_byte_shift
// Purpose: shifts decoded bits MSB first. It publishes each completed byte
//          with a one-cycle strobe and keeps the error flag.
// Assumes: take_i and tmo_i are never high in the same cycle.
module mdec_byte_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              bit_i,
    input  logic              tmo_i,
    output logic [DATA_W-1:0] byte_o,
    output logic              valid_o,
    output logic              err_o
);
    localparam int BC_W = $clog2(DATA_W);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DATA_W - 1);

    logic [DATA_W-1:0] shreg_q;
    logic [DATA_W-1:0] shnext;
    logic [BC_W-1:0]   bcnt_q;
    logic              full;

    assign shnext = {shreg_q[DATA_W-2:0], bit_i};
    assign full   = take_i && (bcnt_q == LAST_BIT);

    // Shift register: takes one bit per accepted centre edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (take_i) begin
            shreg_q <= shnext;
        end
    end

    // Bit counter: advances per bit, wraps on a full byte, clears on timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt_q <= '0;
        end else if (tmo_i || full) begin
            bcnt_q <= '0;
        end else if (take_i) begin
            bcnt_q <= bcnt_q + 1'b1;
        end
    end

    // Output byte and strobe: loaded only when a byte completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= full;
            if (full) begin
                byte_o <= shnext;
            end
        end
    end

    // Error flag: set by timeout, cleared by a completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else if (tmo_i) begin
            err_o <= 1'b1;
        end else if (full) begin
            err_o <= 1'b0;
        end
    end

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_byte_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(byte_o) |-> valid_o);

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(tmo_i));

    assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !err_o);
endmodule

// File: rtl/manch_byte_rx.sv
// Module: manch_byte_rx (top)
// Purpose: Manchester byte receiver at 16x oversampling. The chain is
//          synchroniser, then centre-edge timer, then MSB-first byte assembly.
// Assumes: before a frame the line rests at the first half-cell level of its
//          first bit; windows are derived from the cell length.
module manch_byte_rx
    import mdec_pkg::*;
#(
    parameter int CELL_CYC    = DEF_CELL_CYC,
    parameter int DATA_W      = DEF_DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    output logic [DATA_W-1:0] byte_out,
    output logic              byte_valid,
    output logic              err
);
    localparam int BLANK_CYC = (CELL_CYC * 3) / 4;
    localparam int TMO_CYC   = (CELL_CYC * 3) / 2;

    line_edge_t line_edge;
    logic       take;
    logic       dbit;
    logic       tmo;

    mdec_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(line_in),
        .edge_o (line_edge)
    );

    mdec_cell_timer #(.BLANK_CYC(BLANK_CYC), .TMO_CYC(TMO_CYC)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .edge_i(line_edge),
        .take_o(take),
        .bit_o (dbit),
        .tmo_o (tmo)
    );

    mdec_byte_shift #(.DATA_W(DATA_W)) i_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take),
        .bit_i  (dbit),
        .tmo_i  (tmo),
        .byte_o (byte_out),
        .valid_o(byte_valid),
        .err_o  (err)
    );
endmodule

// File: tb/test_manch_byte_rx.sv
module test_manch_byte_rx;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_in = 1'b0;
    logic [7:0] byte_out;
    logic       byte_valid;
    logic       err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int got_cnt = 0;
    logic [7:0] got_byte = 8'h00;
    int valid_cyc = 0;
    int last_mid_cyc = 0;
    logic prev_valid = 1'b0;

    manch_byte_rx i_manch_byte_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .byte_out  (byte_out),
        .byte_valid(byte_valid),
        .err       (err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Strobe monitor: records each byte and checks the strobe width (R3).
    always @(negedge clk) begin
        if (rst_n && byte_valid) begin
            got_cnt++;
            got_byte = byte_out;
            valid_cyc = cyc;
            check(!prev_valid, "R3", "strobe longer than one clock", 1, 0);
        end
        prev_valid = byte_valid;
    end

    task automatic do_reset(input logic lvl);
        @(negedge clk);
        rst_n = 1'b0;
        line_in = lvl;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    // One bit: first-half level, then the inverted level after the centre.
    task automatic send_bit(input logic b, input int h1, input int h2);
        line_in = b;
        repeat (h1) @(negedge clk);
        line_in = ~b;
        last_mid_cyc = cyc;
        repeat (h2) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i], 8, 8);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0;
        line_in = 1'b1;
        repeat (3) @(negedge clk);
        check(byte_out == 8'h00, "R1", "byte_out in reset", byte_out, 0);
        check(byte_valid == 1'b0, "R1", "valid in reset", byte_valid, 0);
        check(err == 1'b0, "R1", "err in reset", err, 0);
        rst_n = 1'b1;
        line_in = 1'b1;
        repeat (6) @(negedge clk);
        check(got_cnt == 0, "R10", "no byte from reset level", got_cnt, 0);
    endtask

    task automatic t_basic;
        int n0;
        do_reset(1'b1);
        n0 = got_cnt;
        send_byte(8'hB9);
        check(got_cnt == n0 + 1, "R3", "one byte for 0xB9", got_cnt - n0, 1);
        check(got_byte == 8'hB9, "R2", "decoded 0xB9", got_byte, 8'hB9);
        check(valid_cyc == last_mid_cyc + 3, "R5", "strobe latency",
              valid_cyc - last_mid_cyc, 3);
        check(err == 1'b0, "R9", "err low after good byte", err, 0);
        repeat (40) @(negedge clk);
        check(err == 1'b1, "R8", "err after idle", err, 1);
        check(byte_out == 8'hB9, "R4", "byte held through idle", byte_out, 8'hB9);
        check(got_cnt == n0 + 1, "R4", "no extra strobe in idle", got_cnt - n0, 1);
    endtask

    task automatic t_stream;
        logic [7:0] seq [4] = '{8'h5A, 8'h00, 8'hFF, 8'h81};
        int n0;
        do_reset(1'b0);
        n0 = got_cnt;
        for (int k = 0; k < 4; k++) begin
            send_byte(seq[k]);
            check(got_byte == seq[k], "R6", "back-to-back byte", got_byte, seq[k]);
            check(err == 1'b0, "R9", "err low in stream", err, 0);
        end
        check(got_cnt == n0 + 4, "R3", "four strobes", got_cnt - n0, 4);
    endtask

    task automatic t_jitter;
        logic [7:0] v = 8'h3C;
        do_reset(1'b0);
        for (int i = 7; i >= 0; i--)
            send_bit(v[i], 7 + (i % 3), 7 + ((i + 1) % 3));
        check(got_byte == 8'h3C, "R7", "byte with jittered cells", got_byte, 8'h3C);
        check(err == 1'b0, "R7", "no error under jitter", err, 0);
    endtask

    task automatic t_glitch;
        logic [7:0] v = 8'hA5;
        int n0;
        do_reset(1'b1);
        n0 = got_cnt;
        for (int i = 7; i >= 0; i--) begin
            if (i == 4) begin
                line_in = v[i];
                repeat (8) @(negedge clk);
                line_in = ~v[i];
                repeat (3) @(negedge clk);
                line_in = v[i];
                repeat (2) @(negedge clk);
                line_in = ~v[i];
                repeat (3) @(negedge clk);
            end else begin
                send_bit(v[i], 8, 8);
            end
        end
        check(got_byte == 8'hA5, "R6", "glitch ignored", got_byte, 8'hA5);
        check(got_cnt == n0 + 1, "R6", "single strobe with glitch", got_cnt - n0, 1);
    endtask

    task automatic t_timeout;
        int n0;
        do_reset(1'b1);
        n0 = got_cnt;
        for (int i = 0; i < 4; i++) send_bit(1'b1, 8, 8);
        repeat (40) @(negedge clk);
        check(err == 1'b1, "R8", "err after partial byte", err, 1);
        check(got_cnt == n0, "R8", "no strobe for partial byte", got_cnt - n0, 0);
        send_byte(8'h3C);
        check(got_cnt == n0 + 1, "R8", "fresh byte after timeout", got_cnt - n0, 1);
        check(got_byte == 8'h3C, "R8", "bit count restarted", got_byte, 8'h3C);
        check(err == 1'b0, "R9", "err cleared by byte", err, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_stream();
        t_jitter();
        t_glitch();
        t_timeout();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule